// File: doc/BRIEF.md
# Per-Shifter Buffer Error Flag Register

This block keeps one sticky error flag for each of four shifters. Each shifter owns a single data buffer and runs in one of four modes: receive, transmit, match-store or match-continuous. The block follows whether each buffer holds data that has not been consumed yet. Strobes from the shift engine (data stored, data loaded, framing check failed, match seen) are weighed against that occupancy. A strobe that would overwrite unread data, or that would consume data never supplied, raises the shifter's flag. A bad framing bit also raises it, and so does any match in match-continuous mode.

The flags appear in the low bits of a 32-bit status word. A host clears a flag by writing 1 to its bit. In match-continuous mode, reading that shifter's buffer also clears the flag. Buffer reads and writes from the bus arrive as per-shifter one-cycle strobes. The status word is combinational from the flag registers, so an event strobed in one cycle is visible right after the next rising clock edge.

Top module: `shifter_err_flags`

## Requirements
- R1: After reset every flag is 0, every buffer counts as empty, and the status word reads 0.
- R2: Bit i of the status word is shifter i's flag (i = 0..3). Bits 31:4 always read 0, and writes to them have no effect.
- R3: A status write with bit i = 1 clears flag i. A bit written as 0 leaves its flag unchanged.
- R4: Mode code 0 is receive. A store strobe marks the buffer full and a buffer read empties it. A store while the buffer is full and not read in the same cycle sets the flag (overrun).
- R5: In receive mode, a framing-bit-mismatch strobe sets the flag.
- R6: Mode code 1 is transmit. A buffer write marks the buffer full. A load empties it, except that a write in the same cycle refills it. When the buffer is empty, a write together with a load is consumed directly and leaves it empty. A load with the buffer empty and no write in the same cycle sets the flag (underrun).
- R7: Mode code 2 is match-store. A match marks the buffer full and a buffer read empties it. A match while the buffer is full and not read in the same cycle sets the flag.
- R8: Mode code 3 is match-continuous. Every match sets the flag, a buffer read of that shifter clears it, and the buffer counts as empty.
- R9: When a set condition and a clear (write-1 or read) happen in the same cycle, the flag ends at 1.
- R10: Strobes that have no meaning in a shifter's current mode are ignored. These are: framing strobes outside receive, load strobes outside transmit, and buffer reads outside match-continuous (as a clear path).
- R11: The four shifters are independent. Each follows only its own mode field and strobes, and mode changes take effect on the next cycle's strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 8 | Mode of shifter i in bits 2i+1:2i (0 rx, 1 tx, 2 match-store, 3 match-continuous) |
| sh_store_i | input | 4 | Shifter stores received data into its buffer |
| sh_load_i | input | 4 | Shifter loads transmit data from its buffer |
| frame_bad_i | input | 4 | Received start or stop bit had the wrong value |
| match_i | input | 4 | Compare match event |
| buf_wr_i | input | 4 | Bus write to a shifter buffer |
| buf_rd_i | input | 4 | Bus read of a shifter buffer |
| reg_wr_i | input | 1 | Write strobe for the status word |
| reg_wdata_i | input | 32 | Write data, 1 bits clear flags |
| reg_rdata_o | output | 32 | Status word |

## Verification
The assertions watch every cycle for these rules: a framing failure in receive mode and a match in match-continuous mode always raise the flag, a write-1 without a set condition always clears it, a flag with no event holds its value, and the reserved bits stay zero. Overrun and underrun depend on the buffer-occupancy history. So do the same-cycle tie rules for read against store and write against load. Only the bench scenarios show these, directed per mode and then in a long mixed sweep that rotates the modes across shifters and compares against an arithmetic model.

// File: rtl/sef_pkg.sv
package sef_pkg;
    typedef enum logic [1:0] {
        MODE_RX     = 2'd0,
        MODE_TX     = 2'd1,
        MODE_MSTORE = 2'd2,
        MODE_MCONT  = 2'd3
    } sh_mode_e;

    typedef struct packed {
        logic full;
        logic err;
    } slot_state_t;
endpackage

// File: rtl/sef_slot.sv
module sef_slot
    import sef_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] mode_i,
    input  logic       store_i,
    input  logic       load_i,
    input  logic       frame_bad_i,
    input  logic       match_i,
    input  logic       buf_wr_i,
    input  logic       buf_rd_i,
    input  logic       clr_i,
    output logic       err_o
);
    sh_mode_e    mode;
    slot_state_t st_d, st_q;
    logic        set_ev;
    logic        rd_clr;

    always_comb begin
        mode   = sh_mode_e'(mode_i);
        st_d   = st_q;
        set_ev = 1'b0;
        rd_clr = 1'b0;
        unique case (mode)
            MODE_RX: begin
                set_ev    = frame_bad_i | (store_i & st_q.full & ~buf_rd_i);
                st_d.full = store_i | (st_q.full & ~buf_rd_i);
            end
            MODE_TX: begin
                set_ev    = load_i & ~st_q.full & ~buf_wr_i;
                st_d.full = st_q.full ? (buf_wr_i | ~load_i) : (buf_wr_i & ~load_i);
            end
            MODE_MSTORE: begin
                set_ev    = match_i & st_q.full & ~buf_rd_i;
                st_d.full = match_i | (st_q.full & ~buf_rd_i);
            end
            MODE_MCONT: begin
                set_ev    = match_i;
                st_d.full = 1'b0;
                rd_clr    = buf_rd_i;
            end
            default: begin
                set_ev    = 1'b0;
            end
        endcase
        st_d.err = set_ev | (st_q.err & ~(clr_i | rd_clr));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_o = st_q.err;

    p_frame_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd0 && frame_bad_i) |=> err_o);

    p_mcont_match_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == 2'd3 && match_i) |=> err_o);

    p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_ev) |=> !err_o);

    p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (set_ev && (clr_i || buf_rd_i)) |=> err_o);

    p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_ev && !clr_i && !rd_clr) |=> $stable(err_o));
endmodule

// File: rtl/sef_csr.sv
module sef_csr #(
    parameter int NUM_SH = 4,
    parameter int REG_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_i,
    input  logic [REG_W-1:0]  reg_wdata_i,
    input  logic [NUM_SH-1:0] err_i,
    output logic [NUM_SH-1:0] clr_o,
    output logic [REG_W-1:0]  rdata_o
);
    localparam int RESV_W = REG_W - NUM_SH;

    logic resv_unused;
    assign resv_unused = ^reg_wdata_i[REG_W-1:NUM_SH];

    always_comb begin
        clr_o   = reg_wr_i ? reg_wdata_i[NUM_SH-1:0] : '0;
        rdata_o = {{RESV_W{1'b0}}, err_i};
    end

    p_resv_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_o[REG_W-1:NUM_SH] == '0);

    p_clr_needs_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|clr_o) |-> reg_wr_i);
endmodule

// File: rtl/shifter_err_flags.sv
module shifter_err_flags
    import sef_pkg::*;
#(
    parameter int NUM_SH = 4,
    parameter int REG_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*NUM_SH-1:0]   mode_i,
    input  logic [NUM_SH-1:0]     sh_store_i,
    input  logic [NUM_SH-1:0]     sh_load_i,
    input  logic [NUM_SH-1:0]     frame_bad_i,
    input  logic [NUM_SH-1:0]     match_i,
    input  logic [NUM_SH-1:0]     buf_wr_i,
    input  logic [NUM_SH-1:0]     buf_rd_i,
    input  logic                  reg_wr_i,
    input  logic [REG_W-1:0]      reg_wdata_i,
    output logic [REG_W-1:0]      reg_rdata_o
);
    logic [NUM_SH-1:0] clr;
    logic [NUM_SH-1:0] err;

    for (genvar i = 0; i < NUM_SH; i++) begin : g_slot
        sef_slot u_slot (
            .clk         (clk),
            .rst_n       (rst_n),
            .mode_i      (mode_i[2*i +: 2]),
            .store_i     (sh_store_i[i]),
            .load_i      (sh_load_i[i]),
            .frame_bad_i (frame_bad_i[i]),
            .match_i     (match_i[i]),
            .buf_wr_i    (buf_wr_i[i]),
            .buf_rd_i    (buf_rd_i[i]),
            .clr_i       (clr[i]),
            .err_o       (err[i])
        );
    end

    sef_csr #(.NUM_SH(NUM_SH), .REG_W(REG_W)) u_csr (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wr_i    (reg_wr_i),
        .reg_wdata_i (reg_wdata_i),
        .err_i       (err),
        .clr_o       (clr),
        .rdata_o     (reg_rdata_o)
    );
endmodule

// File: tb/shifter_err_flags_test.sv
module shifter_err_flags_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  mode_i = '0;
    logic [3:0]  sh_store_i = '0, sh_load_i = '0, frame_bad_i = '0, match_i = '0;
    logic [3:0]  buf_wr_i = '0, buf_rd_i = '0;
    logic        reg_wr_i = 1'b0;
    logic [31:0] reg_wdata_i = '0;
    logic [31:0] reg_rdata_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [3:0] m_full = '0;
    logic [3:0] m_err  = '0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    shifter_err_flags uut (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
        .sh_store_i(sh_store_i), .sh_load_i(sh_load_i), .frame_bad_i(frame_bad_i),
        .match_i(match_i), .buf_wr_i(buf_wr_i), .buf_rd_i(buf_rd_i),
        .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o)
    );

    task automatic check(input string tag, input logic [31:0] exp);
        n_chk++;
        if (reg_rdata_o !== exp) begin
            n_bad++;
            $display("FAIL %s: status actual %h expected %h", tag, reg_rdata_o, exp);
        end
    endtask

    task automatic step(input logic [3:0] st, input logic [3:0] ld, input logic [3:0] fb,
                        input logic [3:0] mt, input logic [3:0] wr, input logic [3:0] rd,
                        input logic rw, input logic [31:0] wd);
        for (int i = 0; i < 4; i++) begin
            logic set_now, clr_now, nf;
            set_now = 1'b0;
            clr_now = rw & wd[i];
            nf = m_full[i];
            case (mode_i[2*i +: 2])
                2'd0: begin
                    if (fb[i]) set_now = 1'b1;
                    if (st[i] && m_full[i] && !rd[i]) set_now = 1'b1;
                    if (rd[i]) nf = 1'b0;
                    if (st[i]) nf = 1'b1;
                end
                2'd1: begin
                    if (ld[i] && !m_full[i] && !wr[i]) set_now = 1'b1;
                    if (m_full[i]) nf = wr[i] || !ld[i];
                    else           nf = wr[i] && !ld[i];
                end
                2'd2: begin
                    if (mt[i] && m_full[i] && !rd[i]) set_now = 1'b1;
                    if (rd[i]) nf = 1'b0;
                    if (mt[i]) nf = 1'b1;
                end
                default: begin
                    if (mt[i]) set_now = 1'b1;
                    if (rd[i]) clr_now = 1'b1;
                    nf = 1'b0;
                end
            endcase
            m_full[i] = nf;
            if (set_now)      m_err[i] = 1'b1;
            else if (clr_now) m_err[i] = 1'b0;
        end
        sh_store_i = st; sh_load_i = ld; frame_bad_i = fb; match_i = mt;
        buf_wr_i = wr; buf_rd_i = rd; reg_wr_i = rw; reg_wdata_i = wd;
        @(posedge clk);
        @(negedge clk);
        sh_store_i = '0; sh_load_i = '0; frame_bad_i = '0; match_i = '0;
        buf_wr_i = '0; buf_rd_i = '0; reg_wr_i = 1'b0; reg_wdata_i = '0;
    endtask

    function automatic logic [31:0] expw();
        return {28'd0, m_err};
    endfunction

    task automatic w1c(input logic [31:0] wd);
        step('0, '0, '0, '0, '0, '0, 1'b1, wd);
    endtask

    initial begin
        #(20 * 150000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        lfsr = 16'hACE1;
        mode_i = 8'b11_10_01_00;
        repeat (3) @(negedge clk);
        check("R1 reset value", 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", 32'h0);

        // R5 framing error in receive
        step('0, '0, 4'h1, '0, '0, '0, 1'b0, '0);
        check("R5 frame sets sh0", 32'h1);
        // R3 write-0 keeps, other bits keep, own bit clears
        w1c(32'h0);
        check("R3 write zero keeps", 32'h1);
        w1c(32'h2);
        check("R3 other bit keeps", 32'h1);
        // R2 reserved writes ignored
        w1c(32'hFFFF_FFF0);
        check("R2 reserved write ignored", 32'h1);
        w1c(32'h1);
        check("R3 write one clears", 32'h0);

        // R4 receive overrun
        step(4'h1, '0, '0, '0, '0, '0, 1'b0, '0);
        check("R4 first store no error", 32'h0);
        step(4'h1, '0, '0, '0, '0, '0, 1'b0, '0);
        check("R4 overrun sets", 32'h1);
        w1c(32'h1);
        step(4'h1, '0, '0, '0, '0, 4'h1, 1'b0, '0);
        check("R4 store with same-cycle read", 32'h0);
        step('0, '0, '0, '0, '0, 4'h1, 1'b0, '0);
        step(4'h1, '0, '0, '0, '0, '0, 1'b0, '0);
        check("R4 store after read", 32'h0);

        // R6 transmit underrun
        step('0, 4'h2, '0, '0, '0, '0, 1'b0, '0);
        check("R6 load empty underrun", 32'h2);
        w1c(32'h2);
        step('0, '0, '0, '0, 4'h2, '0, 1'b0, '0);
        step('0, 4'h2, '0, '0, '0, '0, 1'b0, '0);
        check("R6 load after write", 32'h0);
        step('0, 4'h2, '0, '0, 4'h2, '0, 1'b0, '0);
        check("R6 load with same-cycle write", 32'h0);
        step('0, 4'h2, '0, '0, '0, '0, 1'b0, '0);
        check("R6 load after direct pass", 32'h2);
        w1c(32'h2);

        // R7 match-store
        step('0, '0, '0, 4'h4, '0, '0, 1'b0, '0);
        check("R7 first match no error", 32'h0);
        step('0, '0, '0, 4'h4, '0, '0, 1'b0, '0);
        check("R7 unread match sets", 32'h4);
        w1c(32'h4);
        step('0, '0, '0, '0, '0, 4'h4, 1'b0, '0);
        step('0, '0, '0, 4'h4, '0, '0, 1'b0, '0);
        check("R7 match after read", 32'h0);

        // R8 match-continuous
        step('0, '0, '0, 4'h8, '0, '0, 1'b0, '0);
        check("R8 match sets", 32'h8);
        step('0, '0, '0, '0, '0, 4'h8, 1'b0, '0);
        check("R8 read clears", 32'h0);
        step('0, '0, '0, 4'h8, '0, '0, 1'b0, '0);
        w1c(32'h8);
        check("R8 write one clears", 32'h0);

        // R9 set wins
        step('0, '0, '0, 4'h8, '0, '0, 1'b1, 32'h8);
        check("R9 match beats write-1", 32'h8);
        step('0, '0, '0, 4'h8, '0, 4'h8, 1'b0, '0);
        check("R9 match beats read", 32'h8);
        step('0, '0, 4'h1, '0, '0, '0, 1'b1, 32'h1);
        check("R9 frame beats write-1", 32'h9);
        w1c(32'hF);

        // R10 irrelevant strobes ignored
        step('0, 4'h1, 4'h2, '0, '0, '0, 1'b0, '0);
        check("R10 frame in tx, load in rx", 32'h0);
        step('0, '0, 4'h1, '0, '0, '0, 1'b0, '0);
        step('0, '0, '0, '0, '0, 4'h1, 1'b0, '0);
        check("R10 read in rx keeps flag", 32'h1);
        w1c(32'h1);
        check("R2 upper bits zero", expw());

        // R11 mixed sweep with rotating modes
        for (int k = 0; k < 4096; k++) begin
            logic [3:0] a, b, c, d, e, f;
            logic rw;
            if (k % 256 == 0) mode_i = {mode_i[1:0], mode_i[7:2]} ^ 8'(k / 256);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = lfsr[3:0] & lfsr[7:4];
            b = lfsr[7:4] & lfsr[11:8];
            c = lfsr[11:8] & lfsr[15:12] & lfsr[3:0];
            d = lfsr[15:12] ^ lfsr[1:0];
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            e = lfsr[3:0] & lfsr[11:8];
            f = lfsr[7:4] & lfsr[15:12];
            rw = lfsr[0] & lfsr[5];
            step(a, b, c, d, e, f, rw, {lfsr, lfsr});
            check("R11 sweep", expw());
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule